// File: doc/BRIEF.md
# Ring Oscillator Disturbance Alarm

This block watches a free-running watchdog ring oscillator laid over a sensitive register region, about 64 flops, with the oscillator near 357 MHz. A laser or glitch that disturbs the region changes the oscillator's frequency for a short time. Three taps of the oscillator reach the block with a fixed phase order: early, then sampling, then late. Two capture flops sample the early and late taps on the rising edge of the delayed sampling tap. While the oscillation is steady the captured pair is always early=1, late=0. A slowdown makes the pair read 1,1 and a speedup makes it read 0,0. The XOR of the pair is an active-low raw alarm, so one structure catches a frequency change in either direction.

The raw alarm is brought into the system clock domain through a synchronizer, then edge-detected. One injection usually upsets many oscillator cycles. Only the first accepted falling edge drops the sticky active-low flag and gives a one-cycle marker pulse. Later falling edges are only counted, so the length of the burst can be measured. Alarms are ignored while the oscillator is disabled, and also for a settling window after it is enabled. A synchronous clear returns the flag to the safe state.

Top module: `osc_disturb_alarm`

## Requirements
- R1: After reset, latched_alarm_no=1, first_edge_o=0, burst_count_o=0 and osc_en_o=0.
- R2: While the captured pair stays early=1, late=0, the latched flag stays 1 and the counter stays 0.
- R3: A slowdown pair (1,1) captured on a sampling edge, with the gate armed, drives latched_alarm_no to 0. This happens on the third rising clk edge after the sampling edge that captured it, counting two synchronizer flops and one edge-detect flop. The flag then stays 0 until clear.
- R4: A speedup pair (0,0) captured under the same conditions sets the flag with the same timing as R3.
- R5: first_edge_o is high for exactly one clk cycle, in the cycle the flag first drops. It never pulses while the flag is already 0.
- R6: Each accepted falling edge of the raw alarm while the flag is already 0 adds one to burst_count_o (8 bits). The counter saturates at 255.
- R7: clear_i high at a clk edge sets the flag to 1, the counter to 0 and first_edge_o to 0. Clear wins over an accepted edge in the same cycle.
- R8: While osc_en_i is low, raw alarm edges change no output. osc_en_o always equals osc_en_i.
- R9: An edge is accepted only if osc_en_i has been high at the SETTLE_SAMPLES (default 4) clk edges before, as well as at the current edge. Edges that arrive earlier are ignored.
- R10: Only falling edges count. A bad pair held for many sampling cycles gives one edge, not one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| osc_en_i | input | 1 | Oscillator enable request (clk domain) |
| tap_early_i | input | 1 | Early oscillator tap |
| tap_smp_i | input | 1 | Delayed sampling tap, used as capture clock |
| tap_late_i | input | 1 | Late oscillator tap |
| clear_i | input | 1 | Synchronous clear of flag and counter |
| osc_en_o | output | 1 | Enable to the oscillator loop |
| latched_alarm_no | output | 1 | Sticky flag, 0 = disturbance seen |
| first_edge_o | output | 1 | One-cycle pulse when the flag drops |
| burst_count_o | output | 8 | Falling edges seen after the first |

## Verification
The assertions assume that osc_en_i and clear_i are synchronous to clk_i. They also assume the taps are stable around each rising edge of tap_smp_i, so the capture flops never go metastable in simulation. The stimulus meets this by driving tap_smp_i as the inverse of clk_i and changing the early and late taps 1 ns after each clk rising edge, well before the next sampling edge. Under these conditions the delay from a bad captured pair to the flag is fixed, so a behavioural reference model can predict the outputs cycle by cycle.

// File: rtl/osc_alarm_pkg.sv
package osc_alarm_pkg;
  localparam int unsigned BURST_W = 8;
  typedef logic [BURST_W-1:0] burst_cnt_t;
endpackage

// File: rtl/osc_tap_capture.sv
module osc_tap_capture (
  input  logic rst_ni,
  input  logic tap_smp_i,
  input  logic tap_early_i,
  input  logic tap_late_i,
  output logic raw_alarm_no
);
  logic cap_early_q, cap_late_q;

  // reset to the steady-state pair so the raw alarm starts safe
  always_ff @(posedge tap_smp_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_early_q <= 1'b1;
      cap_late_q  <= 1'b0;
    end else begin
      cap_early_q <= tap_early_i;
      cap_late_q  <= tap_late_i;
    end
  end

  assign raw_alarm_no = cap_early_q ^ cap_late_q;
endmodule

// File: rtl/osc_alarm_sync.sv
module osc_alarm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/osc_settle_gate.sv
module osc_settle_gate #(
  parameter int unsigned SETTLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(SETTLE + 2);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (!en_i)         run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign armed_o = en_i && (run_q == LIMIT);
endmodule

// File: rtl/osc_first_latch.sv
module osc_first_latch
  import osc_alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       clear_i,
  output logic       latched_no,
  output logic       first_o,
  output burst_cnt_t burst_o
);
  localparam burst_cnt_t CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_no <= 1'b1;
      first_o    <= 1'b0;
      burst_o    <= '0;
    end else if (clear_i) begin
      latched_no <= 1'b1;
      first_o    <= 1'b0;
      burst_o    <= '0;
    end else begin
      first_o <= 1'b0;
      if (hit_i) begin
        if (latched_no) begin
          latched_no <= 1'b0;
          first_o    <= 1'b1;
        end else if (burst_o != CNT_MAX) begin
          burst_o <= burst_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osc_disturb_alarm.sv
module osc_disturb_alarm
  import osc_alarm_pkg::*;
#(
  parameter int unsigned SETTLE_SAMPLES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_en_i,
  input  logic               tap_early_i,
  input  logic               tap_smp_i,
  input  logic               tap_late_i,
  input  logic               clear_i,
  output logic               osc_en_o,
  output logic               latched_alarm_no,
  output logic               first_edge_o,
  output logic [BURST_W-1:0] burst_count_o
);
  logic raw_n, sync_n, sync_d_q, fall, armed;
  burst_cnt_t burst;

  assign osc_en_o = osc_en_i;

  osc_tap_capture u_cap (
    .rst_ni      (rst_ni),
    .tap_smp_i   (tap_smp_i),
    .tap_early_i (tap_early_i),
    .tap_late_i  (tap_late_i),
    .raw_alarm_no(raw_n)
  );

  osc_alarm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_n),
    .q_o   (sync_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_d_q <= 1'b1;
    else         sync_d_q <= sync_n;
  end

  assign fall = sync_d_q & ~sync_n;

  osc_settle_gate #(.SETTLE(SETTLE_SAMPLES)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (osc_en_i),
    .armed_o(armed)
  );

  osc_first_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (fall & armed),
    .clear_i   (clear_i),
    .latched_no(latched_alarm_no),
    .first_o   (first_edge_o),
    .burst_o   (burst)
  );

  assign burst_count_o = burst;
endmodule

// File: rtl/osc_disturb_alarm_chk.sv
module osc_disturb_alarm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_en_i,
  input logic       clear_i,
  input logic       osc_en_o,
  input logic       latched_alarm_no,
  input logic       first_edge_o,
  input logic [7:0] burst_count_o
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_edge_o |=> !first_edge_o);

  a_r5_pulse_with_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_edge_o |-> !latched_alarm_no);

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latched_alarm_no && !clear_i) |=> !latched_alarm_no);

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_count_o == 8'hFF && !clear_i) |=> burst_count_o == 8'hFF);

  a_r6_count_after_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_alarm_no |-> burst_count_o == 8'd0);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (latched_alarm_no && burst_count_o == 8'd0 && !first_edge_o));

  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i && !clear_i) |=>
      ($stable(latched_alarm_no) && $stable(burst_count_o) && !first_edge_o));

  always_comb begin
    if (rst_ni) a_r8_en_pass: assert (osc_en_o == osc_en_i);
  end
endmodule

bind osc_disturb_alarm osc_disturb_alarm_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .osc_en_i        (osc_en_i),
  .clear_i         (clear_i),
  .osc_en_o        (osc_en_o),
  .latched_alarm_no(latched_alarm_no),
  .first_edge_o    (first_edge_o),
  .burst_count_o   (burst_count_o)
);

// File: tb/tb_osc_disturb_alarm.sv
`timescale 1ns/1ps
module tb_osc_disturb_alarm;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_en = 1'b0, early = 1'b1, late = 1'b0, clear = 1'b0;
  logic tap_smp;
  logic osc_en_o, lat_n, first;
  logic [7:0] cnt;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign tap_smp = ~clk;

  osc_disturb_alarm dut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_en_i(osc_en),
    .tap_early_i(early), .tap_smp_i(tap_smp), .tap_late_i(late),
    .clear_i(clear), .osc_en_o(osc_en_o), .latched_alarm_no(lat_n),
    .first_edge_o(first), .burst_count_o(cnt)
  );

  // reference model
  bit raw_q[$] = '{1'b1, 1'b1, 1'b1, 1'b1};
  bit m_lat = 1, m_first = 0;
  int m_cnt = 0, en_run = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lat = 1; m_first = 0; m_cnt = 0; en_run = 0;
    end else begin
      bit fall, acc;
      fall = raw_q[raw_q.size()-4] && !raw_q[raw_q.size()-3];
      acc  = osc_en && (en_run >= SETTLE) && fall;
      en_run = osc_en ? en_run + 1 : 0;
      if (clear) begin
        m_lat = 1; m_cnt = 0; m_first = 0;
      end else begin
        m_first = 0;
        if (acc) begin
          if (m_lat) begin m_lat = 0; m_first = 1; end
          else if (m_cnt < 255) m_cnt++;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R3 latched", lat_n, m_lat);
      chk("R5 first", first, m_first);
      chk("R6 count", cnt, m_cnt);
    end
    raw_q.push_back(early ^ late);
    if (raw_q.size() > 8) void'(raw_q.pop_front());
  end

  task automatic step(logic e, logic l);
    @(posedge clk); #1; early = e; late = l;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
  endtask
  task automatic do_clear();
    @(posedge clk); #1; clear = 1'b1;
    @(posedge clk); #1; clear = 1'b0;
  endtask
  task automatic probe(string req, int act, int exp);
    @(negedge clk); #0.1; chk(req, act, exp);
  endtask

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 latched", lat_n, 1); chk("R1 first", first, 0);
    chk("R1 count", cnt, 0); chk("R1 en_o", osc_en_o, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1; osc_en = 1'b1;
    idle(30);
    probe("R2 stable", lat_n, 1);
    probe("R8 en_o", osc_en_o, 1);

    // slowdown, single sampling cycle
    step(1, 1); idle(6);
    probe("R3 slowdown", lat_n, 0);
    probe("R3 count", cnt, 0);
    do_clear(); idle(3);
    probe("R7 clear flag", lat_n, 1);

    // speedup
    step(0, 0); idle(6);
    probe("R4 speedup", lat_n, 0);
    do_clear(); idle(3);

    // burst of five
    for (int i = 0; i < 5; i++) begin step(1, 1); step(1, 0); end
    idle(6);
    probe("R6 burst", cnt, 4);
    do_clear(); idle(3);
    probe("R7 clear count", cnt, 0);

    // held bad pair
    for (int i = 0; i < 12; i++) step(0, 0);
    idle(6);
    probe("R10 held flag", lat_n, 0);
    probe("R10 held count", cnt, 0);
    do_clear(); idle(3);

    // saturation
    for (int i = 0; i < 300; i++) begin step(1, 1); step(1, 0); end
    idle(6);
    probe("R6 saturate", cnt, 255);

    // clear overlapping an incoming edge
    step(0, 0); step(1, 0);
    @(posedge clk); #1; clear = 1'b1;
    @(posedge clk); #1; clear = 1'b0;
    idle(6);
    probe("R7 clear wins", lat_n, 1);
    do_clear(); idle(3);

    // disabled
    @(posedge clk); #1; osc_en = 1'b0;
    probe("R8 en_o low", osc_en_o, 0);
    for (int i = 0; i < 6; i++) begin step(1, 1); step(1, 0); end
    idle(6);
    probe("R8 disabled", lat_n, 1);

    // inside settling window
    @(posedge clk); #1; osc_en = 1'b1;
    step(0, 0); step(1, 0);
    idle(8);
    probe("R9 settling", lat_n, 1);
    step(1, 1); idle(6);
    probe("R9 armed", lat_n, 0);
    idle(4);
    summary();
  end
endmodule